// File: doc/BRIEF.md
# Selectable power-of-two clock divider

This block takes a single input clock and produces a set of identical complementary output pairs. Each pair carries either the input clock itself or the input divided by 2, 4, 8 or 16. A 3-bit ratio select chooses the ratio. Its top bit acts as a bypass that overrides the two lower bits.

An active-low reset/disable input clears the divider at once and parks every pair in a fixed state: true side low, complement side high. Reset is applied asynchronously. Its release is synchronized to the input clock, so the first divided edge after release falls on a known input edge. The divider is a free-running binary counter, and each divided output is one bit of that counter. This gives a 50% duty cycle at every ratio.

Top module: `pow2_clk_div`

## Requirements
- R1: With `ratio_sel[2]` at 1, the two low select bits choose the ratio: 00 divides by 2, 01 by 4, 10 by 8 and 11 by 16. The all-ones code, which is what tie-high select pins give, is divide-by-16.
- R2: With `ratio_sel[2]` at 0, the true outputs follow the input clock level whenever the block is enabled, and `ratio_sel[1:0]` has no effect.
- R3: For ratio 2^k, the true output is bit k-1 of a counter that advances once per input rising edge. The output therefore has period 2^k input cycles and is high for exactly half of them.
- R4: While `rst_dis_n` is low, every `out_p` bit is 0 and every `out_n` bit is 1, and the divider counter is cleared. This takes effect immediately, without waiting for a clock edge.
- R5: Count input rising edges from 1, starting with the first edge after `rst_dis_n` rises. Outputs become active at edge 2. For ratio 2^k, the first rising output edge comes at edge 2 + 2^(k-1).
- R6: All output pairs carry the same value at all times.
- R7: Each `out_n` bit is the logical inverse of the matching `out_p` bit.
- R8: A change on `ratio_sel` while running takes effect at the next input rising edge and does not disturb the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be passed through or divided |
| rst_dis_n | input | 1 | Active-low reset and output disable; asserts asynchronously |
| ratio_sel | input | 3 | Bit 2: 0 selects bypass, 1 selects divide; bits 1:0 choose the ratio |
| out_p | output | 2 | True side of each output pair |
| out_n | output | 2 | Complement side of each output pair |

## Verification
The select is sampled on an input rising edge, and release passes through a two-stage synchronizer. Every divided result is therefore due on a counted edge after release: the bench expects the counter value to be edge number minus 2, and samples one nanosecond after each rising edge.

In bypass mode the output is the clock level itself. It is checked just after the rising edge, where it is high, and just after the falling edge, where it is low.

Reset assertion has no clock latency. The bench drops the reset in the middle of a high phase and checks the parked level one nanosecond later.

A select change is checked twice: once before the next edge, where the old ratio must still hold, and once after it, where the new ratio must apply.

// File: rtl/pow2_clk_div.sv
module pow2_clk_div #(
  parameter int NUM_PAIRS   = 2,
  parameter int DIV_BITS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_in,
  input  logic                 rst_dis_n,
  input  logic [$clog2(DIV_BITS):0] ratio_sel,
  output logic [NUM_PAIRS-1:0] out_p,
  output logic [NUM_PAIRS-1:0] out_n
);
  localparam int IDX_W = $clog2(DIV_BITS);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [DIV_BITS-1:0]    cnt;
  logic [IDX_W:0]         sel_q;
  logic                   run;
  logic                   div_bit;
  logic                   mux_clk;
  logic                   true_lvl;

  // release synchronizer, asynchronous assertion (R4, R5)
  always_ff @(posedge clk_in or negedge rst_dis_n)
    if (!rst_dis_n) sync_q <= '0;
    else            sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};

  assign run = sync_q[SYNC_STAGES-1];

  // free-running divider counter (R3)
  always_ff @(posedge clk_in or negedge rst_dis_n)
    if (!rst_dis_n) cnt <= '0;
    else if (!run)  cnt <= '0;
    else            cnt <= cnt + 1'b1;

  // select takes effect on the next input edge (R8)
  always_ff @(posedge clk_in)
    sel_q <= ratio_sel;

  assign div_bit  = cnt[sel_q[IDX_W-1:0]];
  assign mux_clk  = sel_q[IDX_W] ? div_bit : clk_in;
  assign true_lvl = run & mux_clk;

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign out_p[g] = true_lvl;
    assign out_n[g] = ~true_lvl;
  end

  a_r4_parked: assert property (@(posedge clk_in)
    !rst_dis_n |-> (out_p == '0 && out_n == '1));

  a_r3_count_step: assert property (@(posedge clk_in) disable iff (!rst_dis_n)
    (run && $past(run)) |-> cnt == $past(cnt) + 1'b1);

  a_r5_release_clear: assert property (@(posedge clk_in) disable iff (!rst_dis_n)
    $rose(run) |-> cnt == '0);

  a_r2_bypass_low: assert property (@(posedge clk_in) disable iff (!rst_dis_n)
    (run && !sel_q[IDX_W]) |-> out_p == '0);

  a_r5_idle_before_run: assert property (@(posedge clk_in) disable iff (!rst_dis_n)
    !run |-> (out_p == '0 && cnt == '0));
endmodule

// File: tb/test_pow2_clk_div.sv
`timescale 1ns/1ps
module test_pow2_clk_div;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b111;
  logic [1:0] qp, qn;
  int checks = 0;
  int fails = 0;

  localparam logic [2:0] VSEL [8] = '{3'b000, 3'b001, 3'b010, 3'b011,
                                      3'b100, 3'b101, 3'b110, 3'b111};
  localparam int VLOG [8] = '{0, 0, 0, 0, 1, 2, 3, 4};

  always #4 clk = ~clk;

  pow2_clk_div i_pow2_clk_div (
    .clk_in(clk), .rst_dis_n(rst_n), .ratio_sel(sel), .out_p(qp), .out_n(qn));

  task automatic chk(input string req, input logic e);
    checks++;
    if (qp !== {2{e}} || qn !== {2{~e}}) begin
      fails++;
      $display("FAIL %s (pairs R6, complement R7): out_p=%b out_n=%b expected out_p=%b out_n=%b",
               req, qp, qn, {2{e}}, {2{~e}});
    end
  endtask

  function automatic logic model(input int lg, input int n);
    int c;
    if (n < 2) return 1'b0;
    if (lg == 0) return 1'b1;
    c = (n - 2) % 16;
    return logic'((c >> (lg - 1)) & 1);
  endfunction

  task automatic start(input logic [2:0] s);
    @(negedge clk);
    rst_n = 1'b0;
    sel = s;
    repeat (2) @(negedge clk);
    #1 chk("R4", 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic run_edges(input int lg, input int first, input int last);
    for (int n = first; n <= last; n++) begin
      @(posedge clk); #1;
      if (lg == 0) chk("R2", model(0, n));
      else if (n <= 2 + (1 << (lg - 1))) chk("R5", model(lg, n));
      else chk("R1/R3", model(lg, n));
      if (lg == 0) begin
        @(negedge clk); #1 chk("R2", 1'b0);
      end
    end
  endtask

  initial begin
    #2 chk("R4", 1'b0);
    for (int v = 0; v < 8; v++) begin
      start(VSEL[v]);
      run_edges(VLOG[v], 1, 40);
    end

    // R8: ratio change mid-run
    start(3'b111);
    run_edges(4, 1, 20);
    @(negedge clk); sel = 3'b101;
    #1 chk("R8", model(4, 20));
    @(posedge clk); #1 chk("R8", model(2, 21));
    @(posedge clk); #1 chk("R8", model(2, 22));
    @(negedge clk); sel = 3'b000;
    #1 chk("R8", model(2, 22));
    @(posedge clk); #1 chk("R2", 1'b1);
    @(negedge clk); #1 chk("R2", 1'b0);

    // R4: asynchronous disable while divided output is high
    start(3'b111);
    run_edges(4, 1, 14);
    #1 chk("R3", 1'b1);
    rst_n = 1'b0;
    #1 chk("R4", 1'b0);
    start(3'b111);
    run_edges(4, 1, 12);

    // R4: asynchronous disable during a bypass high phase
    start(3'b011);
    run_edges(0, 1, 3);
    @(posedge clk); #1 chk("R2", 1'b1);
    rst_n = 1'b0;
    #1 chk("R4", 1'b0);
    @(posedge clk); #1 chk("R4", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule